// File: doc/BRIEF.md
# Card-Specific Data Register with Field Write Rules

This block holds the 128-bit card-specific data image of a storage device. It also decides which parts of that image a host program operation may change. A program operation presents a complete new image together with a flag that says whether its checksum was found valid. The block compares the new image with the stored one field by field and then either accepts the whole image or rejects the whole image.

The upper 112 bits are fixed at manufacture. The file-format group, copy, permanent-protect and file-format bits are one-time programmable: each may go from 0 to 1 but never back. The temporary-protect bit, the ECC type field and the 7-bit checksum field may be rewritten freely. The two protect bits drive the write and erase permission outputs. Permanent protection overrides everything else, and an external veto input can forbid setting it.

Storage is modelled with flip-flops that are loaded from a factory image on the synchronous reset `rst`. Three other reset inputs stand for supply loss, a hardware reset pin and a reset command. Each of them clears the operation status, and the stored image survives all three.

Top module: `card_spec_reg`

## Requirements
- R1: After `rst` the image equals the factory parameter with bit 0 forced to 1. Bit 0 of `rd_image` reads 1 whatever value is programmed into it, and an operation that differs only in bit 0 is accepted.
- R2: An operation whose bits [127:16] differ from the stored image is rejected as a whole: the image is unchanged and status bit 19 is set.
- R3: The one-time bits are 15, 14, 13, 11 and 10. Each may be set from 0 to 1. An operation that would clear one of these bits while it is set is rejected as a whole and sets status bit 19.
- R4: Bit 12 (temporary protect), bits [9:8] (ECC type) and bits [7:1] (checksum) can be set and cleared by any number of accepted operations.
- R5: `write_allowed` and `erase_allowed` are low exactly when image bit 13 or bit 12 is set. They change one clock after the edge at which `prog_done` rises.
- R6: While bit 13 is set, clearing bit 12 leaves `write_allowed` low.
- R7: When `perm_wp_disable` is high, an operation that would set bit 13 from 0 is rejected and sets status bit 19.
- R8: An operation with `prog_crc_ok` low is rejected with the image unchanged. It sets status bit 23 and leaves bit 19 clear.
- R9: A pulse on `pwr_loss_rst`, `hw_rst` or `cmd_rst` clears `status` and `prog_done` and keeps the image. A program operation in the same cycle as one of these pulses is dropped.
- R10: `prog_done` is high in the cycle after `prog_valid` is sampled. `status` then holds the result of that operation, with every bit other than 19 and 23 zero, and an accepted operation leaves both of those bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high factory initialisation |
| pwr_loss_rst | input | 1 | Supply-loss reset pulse |
| hw_rst | input | 1 | Hardware reset pin pulse |
| cmd_rst | input | 1 | Reset-command pulse |
| prog_valid | input | 1 | Program operation strobe |
| prog_data | input | 128 | Complete new register image |
| prog_crc_ok | input | 1 | Checksum of `prog_data` found valid |
| perm_wp_disable | input | 1 | Veto on setting permanent protection |
| rd_image | output | 128 | Stored readable image |
| prog_done | output | 1 | Operation result valid |
| status | output | 32 | Result of the last operation (bit 19 rule error, bit 23 checksum error) |
| write_allowed | output | 1 | Data writes permitted |
| erase_allowed | output | 1 | Erase permitted |

## Verification
The assertions assume that `rst` is held high from time zero through at least two clock edges, so that the image and the permission register are loaded before any property is enabled. They also assume that every input is a settled 0 or 1 at each rising edge. The bench changes every input at the falling edge and holds `prog_valid` high for one cycle per operation. Each reset pulse lasts one cycle. The bench only combines a reset pulse with a program operation when it checks on purpose that the operation is dropped.

// File: rtl/card_spec_pkg.sv
package card_spec_pkg;
  localparam int IMG_W    = 128;
  localparam int RO_LSB   = 16;
  localparam int PERM_BIT = 13;
  localparam int TMP_BIT  = 12;
  // one-time bits: 15, 14, 13, 11, 10
  localparam logic [IMG_W-1:0] OTP_MASK = {{(IMG_W-16){1'b0}}, 16'hEC00};
  // multiply writable: 12, 9:8, 7:1
  localparam logic [IMG_W-1:0] MW_MASK  = {{(IMG_W-16){1'b0}}, 16'h13FE};

  typedef struct packed {
    logic ok;
    logic crc_bad;
    logic rule_bad;
  } verdict_t;
endpackage

// File: rtl/card_spec_rules.sv
module card_spec_rules
  import card_spec_pkg::*;
(
  input  logic [IMG_W-1:0] cur_img,
  input  logic [IMG_W-1:0] new_img,
  input  logic             crc_ok,
  input  logic             perm_veto,
  output verdict_t         verdict
);
  logic ro_touch;
  logic otp_clear;
  logic perm_blocked;
  logic fixed_touch;

  always_comb begin
    ro_touch     = (cur_img[IMG_W-1:RO_LSB] != new_img[IMG_W-1:RO_LSB]);
    otp_clear    = |(cur_img & ~new_img & OTP_MASK);
    perm_blocked = perm_veto && new_img[PERM_BIT] && !cur_img[PERM_BIT];
    // bits outside all masks below RO_LSB (only bit 0) are forced, never compared
    fixed_touch  = 1'b0;
    verdict.crc_bad  = !crc_ok;
    verdict.rule_bad = crc_ok && (ro_touch || otp_clear || perm_blocked || fixed_touch);
    verdict.ok       = !verdict.crc_bad && !verdict.rule_bad;
  end
endmodule

// File: rtl/card_spec_store.sv
module card_spec_store
  import card_spec_pkg::*;
#(
  parameter logic [IMG_W-1:0] FACTORY_IMG = '0
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [IMG_W-1:0] load_img,
  output logic [IMG_W-1:0] img_q
);
  localparam logic [IMG_W-1:0] ONE_LSB = {{(IMG_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)          img_q <= FACTORY_IMG | ONE_LSB;
    else if (load_en) img_q <= load_img;
  end

  AST_RO_STABLE: assert property (@(posedge clk) disable iff (rst)
    load_en |=> $stable(img_q[IMG_W-1:RO_LSB])); // R2
  AST_OTP_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (($past(img_q) & ~img_q & OTP_MASK) == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(img_q)); // R8
endmodule

// File: rtl/card_spec_status.sv
module card_spec_status
  import card_spec_pkg::*;
#(
  parameter int STATUS_W = 32,
  parameter int GEN_BIT  = 19,
  parameter int CRC_BIT  = 23
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                soft_rst,
  input  logic                fire,
  input  verdict_t            verdict,
  input  logic                perm_bit,
  input  logic                tmp_bit,
  output logic                done_q,
  output logic [STATUS_W-1:0] status_q,
  output logic                allow_q
);
  logic [STATUS_W-1:0] result;

  always_comb begin
    result          = '0;
    result[GEN_BIT] = verdict.rule_bad;
    result[CRC_BIT] = verdict.crc_bad;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      done_q   <= 1'b0;
      status_q <= '0;
    end else begin
      done_q <= fire;
      if (fire) status_q <= result;
    end
  end

  // permission follows the stored image one cycle later; permanent dominates
  always_ff @(posedge clk) allow_q <= !(perm_bit || tmp_bit);

  AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (perm_bit || tmp_bit) |=> !allow_q); // R5
  AST_PERM_DOMINATES: assert property (@(posedge clk) disable iff (rst)
    (perm_bit && !tmp_bit) |=> !allow_q); // R6
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(status_q[GEN_BIT] && status_q[CRC_BIT])); // R8
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (status_q == '0) && !done_q); // R9
endmodule

// File: rtl/card_spec_reg.sv
module card_spec_reg
  import card_spec_pkg::*;
#(
  parameter logic [IMG_W-1:0] FACTORY_IMG = 128'h905E002A1F5A83C7B6DB7FFF96800001,
  parameter int STATUS_W = 32,
  parameter int GEN_BIT  = 19,
  parameter int CRC_BIT  = 23
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                pwr_loss_rst,
  input  logic                hw_rst,
  input  logic                cmd_rst,
  input  logic                prog_valid,
  input  logic [IMG_W-1:0]    prog_data,
  input  logic                prog_crc_ok,
  input  logic                perm_wp_disable,
  output logic [IMG_W-1:0]    rd_image,
  output logic                prog_done,
  output logic [STATUS_W-1:0] status,
  output logic                write_allowed,
  output logic                erase_allowed
);
  localparam logic [IMG_W-1:0] ONE_LSB = {{(IMG_W-1){1'b0}}, 1'b1};

  logic             soft_rst;
  logic             fire;
  logic [IMG_W-1:0] cand;
  logic [IMG_W-1:0] img_q;
  verdict_t         verdict;
  logic             allow_q;

  assign soft_rst = pwr_loss_rst || hw_rst || cmd_rst;
  assign fire     = prog_valid && !soft_rst;
  assign cand     = prog_data | ONE_LSB;

  card_spec_rules u_rules (
    .cur_img   (img_q),
    .new_img   (cand),
    .crc_ok    (prog_crc_ok),
    .perm_veto (perm_wp_disable),
    .verdict   (verdict)
  );

  card_spec_store #(.FACTORY_IMG(FACTORY_IMG)) u_store (
    .clk      (clk),
    .rst      (rst),
    .load_en  (fire && verdict.ok),
    .load_img (cand),
    .img_q    (img_q)
  );

  card_spec_status #(.STATUS_W(STATUS_W), .GEN_BIT(GEN_BIT), .CRC_BIT(CRC_BIT)) u_status (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .fire     (fire),
    .verdict  (verdict),
    .perm_bit (img_q[PERM_BIT]),
    .tmp_bit  (img_q[TMP_BIT]),
    .done_q   (prog_done),
    .status_q (status),
    .allow_q  (allow_q)
  );

  assign rd_image      = img_q;
  assign write_allowed = allow_q;
  assign erase_allowed = allow_q;

  AST_VETO_PERM: assert property (@(posedge clk) disable iff (rst)
    (fire && perm_wp_disable && !img_q[PERM_BIT] && prog_data[PERM_BIT]) |=> !img_q[PERM_BIT]); // R7
  AST_CRC_REJECT: assert property (@(posedge clk) disable iff (rst)
    (prog_valid && !prog_crc_ok) |=> $stable(img_q)); // R8
  AST_RESET_RETAIN: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> $stable(img_q)); // R9
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    fire |=> prog_done); // R10
endmodule

// File: tb/card_spec_reg_tb.sv
`timescale 1ns/1ps
module card_spec_reg_tb;
  localparam logic [127:0] DEF = 128'h905E002A1F5A83C7B6DB7FFF96800001;
  localparam logic [111:0] UP  = DEF[127:16];

  // {ro_flip, crc_ok, veto, in16, exp16, exp_gen, exp_crc, exp_allow}
  localparam int NV = 12;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,16'h1001,16'h1001,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,16'h01AB,16'h01AB,1'b0,1'b0,1'b1},
    {1'b0,1'b0,1'b0,16'h1001,16'h01AB,1'b0,1'b1,1'b1},
    {1'b1,1'b1,1'b0,16'h01AB,16'h01AB,1'b1,1'b0,1'b1},
    {1'b0,1'b1,1'b0,16'hC9AB,16'hC9AB,1'b0,1'b0,1'b1},
    {1'b0,1'b1,1'b0,16'h89AB,16'hC9AB,1'b1,1'b0,1'b1},
    {1'b0,1'b1,1'b1,16'hE9AB,16'hC9AB,1'b1,1'b0,1'b1},
    {1'b0,1'b1,1'b0,16'hC9AA,16'hC9AB,1'b0,1'b0,1'b1},
    {1'b0,1'b1,1'b0,16'hE9AB,16'hE9AB,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,16'hF9AB,16'hF9AB,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,16'hE9AB,16'hE9AB,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,16'hC9AB,16'hE9AB,1'b1,1'b0,1'b0}
  };

  logic clk = 1'b0;
  logic rst, pwr_loss_rst, hw_rst, cmd_rst, prog_valid, prog_crc_ok, perm_wp_disable;
  logic [127:0] prog_data;
  logic [127:0] rd_image;
  logic [31:0]  status;
  logic prog_done, write_allowed, erase_allowed;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  card_spec_reg u_dut (
    .clk(clk), .rst(rst), .pwr_loss_rst(pwr_loss_rst), .hw_rst(hw_rst), .cmd_rst(cmd_rst),
    .prog_valid(prog_valid), .prog_data(prog_data), .prog_crc_ok(prog_crc_ok),
    .perm_wp_disable(perm_wp_disable), .rd_image(rd_image), .prog_done(prog_done),
    .status(status), .write_allowed(write_allowed), .erase_allowed(erase_allowed)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string row_tag(input int i);
    case (i)
      0, 1, 9: return "R4";
      2:       return "R8";
      3:       return "R2";
      4, 5:    return "R3";
      6:       return "R7";
      7:       return "R1";
      10:      return "R6";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [31:0] st(input logic gen, input logic crc);
    st = '0;
    st[19] = gen;
    st[23] = crc;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic prev_allow;
    rst = 1; pwr_loss_rst = 0; hw_rst = 0; cmd_rst = 0;
    prog_valid = 0; prog_crc_ok = 1; perm_wp_disable = 0; prog_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(posedge clk) #1;
    chk("R1 reset image", rd_image, DEF);
    chk("R10 reset status", {96'b0, status}, 128'b0);
    chk("R10 reset done", {127'b0, prog_done}, 128'b0);
    chk("R5 reset allow", {126'b0, write_allowed, erase_allowed}, {126'b0, 2'b11});
    prev_allow = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      logic [111:0] up;
      v = VEC[i];
      up = UP;
      if (v[37]) up[84] = ~up[84];
      @(negedge clk);
      prog_valid = 1; prog_crc_ok = v[36]; perm_wp_disable = v[35];
      prog_data = {up, v[34:19]};
      @(posedge clk) #1;
      chk({row_tag(i), " image"}, rd_image, {UP, v[18:3]});
      chk({row_tag(i), " status R10"}, {96'b0, status}, {96'b0, st(v[2], v[1])});
      chk("R10 done pulse", {127'b0, prog_done}, 128'b1);
      chk("R5 allow not yet updated", {127'b0, write_allowed}, {127'b0, prev_allow});
      @(negedge clk);
      prog_valid = 0; prog_crc_ok = 1; perm_wp_disable = 0;
      @(posedge clk) #1;
      chk({row_tag(i), " R5 allow"}, {126'b0, write_allowed, erase_allowed}, {126'b0, v[0], v[0]});
      chk("R10 done drops", {127'b0, prog_done}, 128'b0);
      prev_allow = v[0];
    end

    // R9: command reset with simultaneous program operation
    @(negedge clk);
    cmd_rst = 1; prog_valid = 1; prog_data = {UP, 16'hF9AB};
    @(posedge clk) #1;
    chk("R9 cmd image kept, op dropped", rd_image, {UP, 16'hE9AB});
    chk("R9 cmd status cleared", {96'b0, status}, 128'b0);
    chk("R9 cmd done low", {127'b0, prog_done}, 128'b0);
    @(negedge clk) cmd_rst = 0; prog_valid = 0;

    // R9: hardware reset after a failing operation
    @(negedge clk) prog_valid = 1; prog_data = {UP, 16'h01AB};
    @(negedge clk) prog_valid = 0; hw_rst = 1;
    @(posedge clk) #1;
    chk("R9 hw status cleared", {96'b0, status}, 128'b0);
    chk("R9 hw image kept", rd_image, {UP, 16'hE9AB});
    @(negedge clk) hw_rst = 0; pwr_loss_rst = 1;
    @(posedge clk) #1;
    chk("R9 power-loss image kept", rd_image, {UP, 16'hE9AB});
    @(negedge clk) pwr_loss_rst = 0;
    @(posedge clk) #1;
    chk("R5 allow after soft resets", {127'b0, write_allowed}, 128'b0);

    // R1: factory initialisation restores default
    @(negedge clk) rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 0;
    @(posedge clk) #1;
    chk("R1 factory image", rd_image, DEF);
    chk("R5 allow after factory", {127'b0, write_allowed}, 128'b1);
    finish_run();
  end
endmodule